// File: doc/BRIEF.md
# Reversible V-Shaped Modular Adder

This block is a gate-level model of an N-bit modular adder made only of reversible gates: controlled-NOT (Feynman) and controlled-swap (Fredkin). Every gate maps a vector of wires onto itself one to one. The wires are the A operand, the B operand and a single carry line. On the way out, the B wires carry the sum, while the A wires and the carry line come back unchanged, so no garbage bits are left.

The carries are built on an upward ripple. At each lower bit, a controlled-NOT forms `a^b`, and a controlled-swap then moves the next carry onto that bit's A wire. The most significant bit only takes the two sum XORs. A downward ripple then undoes each swap and folds the carry into the B wire. The carry line acts as carry-in.

A second copy of the network, built from the same gates in reverse order, maps a sum back to its B operand. The top module holds both copies, side by side and purely combinational.

Top module: `rev_vadd_top`

## Requirements
- R1: `s_o` equals `(a_i + b_i + anc_i) mod 2^N`, where the carry line `anc_i` is a 1-bit carry-in.
- R2: `a_o` always equals `a_i`.
- R3: `anc_o` always equals `anc_i`, so the carry line leaves holding its input value.
- R4: No carry-out exists. A sum of 2^N or more wraps: with N=4, 0xF+0x1 gives 0x0 and 0x7+0x8 with carry-in 1 gives 0x0.
- R5: The reverse network returns `ia_o == ia_i`, `ianc_o == ianc_i` and `ib_o == (is_i - ia_i - ianc_i) mod 2^N`.
- R6: Feeding the forward outputs (`a_o`, `s_o`, `anc_o`) into the reverse inputs restores the original `a_i`, `b_i` and `anc_i`.
- R7: With N=1, the block degenerates to `s_o = a_i ^ b_i ^ anc_i`, which is the most-significant-slice-only path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Operand A, forward network |
| b_i | input | N | Operand B, forward network |
| anc_i | input | 1 | Carry line (carry-in), forward network |
| a_o | output | N | A wires after the forward network |
| s_o | output | N | B wires after the forward network (sum) |
| anc_o | output | 1 | Carry line after the forward network |
| ia_i | input | N | A wires into the reverse network |
| is_i | input | N | Sum wires into the reverse network |
| ianc_i | input | 1 | Carry line into the reverse network |
| ia_o | output | N | A wires after the reverse network |
| ib_o | output | N | Recovered B operand |
| ianc_o | output | 1 | Carry line after the reverse network |

## Verification
A fixed table of operand pairs targets long carry chains, all-ones operands and sums that land exactly on 2^N. Together they separate a broken ripple or a missing wrap from a plain XOR.

A 4-bit instance is then swept over every A, B and carry-in value. This shows the carry-in propagates, and the reverse network undoes the forward one for every input, not only for typical ones.

A 16-bit instance gets random operands, which exposes index errors that only show at wider N. A 1-bit instance exercises the path with only the top slice.

// File: rtl/rev_pkg.sv
package rev_pkg;

  typedef enum logic [1:0] {
    SL_MAJ = 2'd0,
    SL_UMS = 2'd1,
    SL_TOP = 2'd2
  } slice_kind_e;

  typedef struct packed {
    logic c;
    logic a;
    logic b;
  } line3_t;

  // controlled-NOT, a controls b
  function automatic line3_t cnot_ab(line3_t l);
    line3_t r = l;
    r.b = l.b ^ l.a;
    return r;
  endfunction

  // controlled-NOT, c controls b
  function automatic line3_t cnot_cb(line3_t l);
    line3_t r = l;
    r.b = l.b ^ l.c;
    return r;
  endfunction

  // controlled-swap of a and c, b controls
  function automatic line3_t cswap_ac(line3_t l);
    line3_t r = l;
    if (l.b) begin
      r.a = l.c;
      r.c = l.a;
    end
    return r;
  endfunction

endpackage

// File: rtl/rev_slice.sv
module rev_slice
  import rev_pkg::*;
#(
  parameter int unsigned W    = 9,
  parameter int unsigned CI   = 0,
  parameter int unsigned AI   = 1,
  parameter int unsigned BI   = 2,
  parameter slice_kind_e KIND = SL_MAJ,
  parameter bit          INV  = 1'b0
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] v_o
);

  line3_t l_in, l_out;

  assign l_in = '{c: v_i[CI], a: v_i[AI], b: v_i[BI]};

  generate
    if (KIND == SL_MAJ) begin : g_maj
      if (!INV) begin : g_fwd
        assign l_out = cswap_ac(cnot_ab(l_in));
      end else begin : g_rev
        assign l_out = cnot_ab(cswap_ac(l_in));
      end
    end else if (KIND == SL_UMS) begin : g_ums
      if (!INV) begin : g_fwd
        assign l_out = cnot_cb(cswap_ac(l_in));
      end else begin : g_rev
        assign l_out = cswap_ac(cnot_cb(l_in));
      end
    end else begin : g_top
      // the two XORs commute, same order both ways
      assign l_out = cnot_cb(cnot_ab(l_in));
    end
  endgenerate

  always_comb begin
    v_o     = v_i;
    v_o[CI] = l_out.c;
    v_o[AI] = l_out.a;
    v_o[BI] = l_out.b;
  end

endmodule

// File: rtl/rev_vnet.sv
module rev_vnet
  import rev_pkg::*;
#(
  parameter int unsigned N   = 4,
  parameter bit          INV = 1'b0
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] a_o,
  output logic [N-1:0] b_o,
  output logic         c_o
);

  localparam int unsigned W  = 2 * N + 1;
  localparam int unsigned NS = 2 * N; // stage vectors incl. input

  logic [W-1:0] st [NS];
  logic [W-1:0] v_in;

  // wire map: 0 = carry line, a_k at 2k+1, b_k at 2k+2
  assign v_in[0] = c_i;
  for (genvar k = 0; k < N; k++) begin : g_pack
    assign v_in[2*k+1] = a_i[k];
    assign v_in[2*k+2] = b_i[k];
    assign a_o[k]      = st[NS-1][2*k+1];
    assign b_o[k]      = st[NS-1][2*k+2];
  end
  assign c_o   = st[NS-1][0];
  assign st[0] = v_in;

  // slice k uses as carry the line left by slice k-1 on its a wire
  for (genvar s = 0; s < NS - 1; s++) begin : g_stage
    localparam bit          FIRST = (s < N - 1);
    localparam bit          MID   = (s == N - 1);
    // forward: maj 0..N-2, top, ums N-2..0 ; reverse mirrors it
    localparam int unsigned KF    = FIRST ? s : (MID ? N - 1 : 2 * N - 2 - s);
    localparam int unsigned K     = KF;
    localparam slice_kind_e KD    = MID ? SL_TOP :
                                    (FIRST ? (INV ? SL_UMS : SL_MAJ)
                                           : (INV ? SL_MAJ : SL_UMS));
    localparam int unsigned CIX   = (K == 0) ? 0 : 2 * K - 1;
    rev_slice #(
      .W   (W),
      .CI  (CIX),
      .AI  (2 * K + 1),
      .BI  (2 * K + 2),
      .KIND(KD),
      .INV (INV)
    ) u_slice (
      .v_i(st[s]),
      .v_o(st[s+1])
    );
  end

endmodule

// File: rtl/rev_vadd_top.sv
module rev_vadd_top #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         anc_i,
  output logic [N-1:0] a_o,
  output logic [N-1:0] s_o,
  output logic         anc_o,
  input  logic [N-1:0] ia_i,
  input  logic [N-1:0] is_i,
  input  logic         ianc_i,
  output logic [N-1:0] ia_o,
  output logic [N-1:0] ib_o,
  output logic         ianc_o
);

  rev_vnet #(.N(N), .INV(1'b0)) u_fwd (
    .a_i(a_i), .b_i(b_i), .c_i(anc_i),
    .a_o(a_o), .b_o(s_o), .c_o(anc_o)
  );

  rev_vnet #(.N(N), .INV(1'b1)) u_rev (
    .a_i(ia_i), .b_i(is_i), .c_i(ianc_i),
    .a_o(ia_o), .b_o(ib_o), .c_o(ianc_o)
  );

endmodule

// File: rtl/rev_vadd_chk.sv
module rev_vadd_chk #(
  parameter int unsigned N = 4
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         anc_i,
  input logic [N-1:0] a_o,
  input logic [N-1:0] s_o,
  input logic         anc_o,
  input logic [N-1:0] ia_i,
  input logic [N-1:0] is_i,
  input logic         ianc_i,
  input logic [N-1:0] ia_o,
  input logic [N-1:0] ib_o,
  input logic         ianc_o
);

  localparam logic [N-1:0] ONE = 1;

  logic [N-1:0] fwd_ref, rev_ref;
  assign fwd_ref = a_i + b_i + (anc_i ? ONE : '0);
  assign rev_ref = is_i - ia_i - (ianc_i ? ONE : '0);

  always_comb begin
    if (!$isunknown({a_i, b_i, anc_i, a_o, s_o, anc_o})) begin
      p_sum_mod_r1: assert (s_o == fwd_ref);
      p_a_kept_r2: assert (a_o == a_i);
      p_anc_kept_r3: assert (anc_o == anc_i);
    end
  end

  always_comb begin
    if (!$isunknown({ia_i, is_i, ianc_i, ia_o, ib_o, ianc_o})) begin
      p_rev_b_r5: assert (ib_o == rev_ref);
      p_rev_a_r5: assert (ia_o == ia_i);
      p_rev_anc_r5: assert (ianc_o == ianc_i);
    end
  end

endmodule

bind rev_vadd_top rev_vadd_chk #(.N(N)) u_chk (.*);

// File: tb/tb_rev_vadd_top.sv
`timescale 1ns/1ps
module tb_rev_vadd_top;

  localparam int unsigned N  = 4;
  localparam int unsigned NW = 16;
  localparam int unsigned NV = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;

  // {a, b, carry-in, expected sum}
  localparam logic [12:0] VEC [NV] = '{
    {4'h0, 4'h0, 1'b0, 4'h0},
    {4'hF, 4'h1, 1'b0, 4'h0},
    {4'hF, 4'hF, 1'b0, 4'hE},
    {4'h7, 4'h8, 1'b1, 4'h0},
    {4'h5, 4'hA, 1'b0, 4'hF},
    {4'h3, 4'hC, 1'b1, 4'h0},
    {4'h9, 4'h6, 1'b1, 4'h0},
    {4'hA, 4'hA, 1'b0, 4'h4}
  };

  logic [N-1:0] a, b, ao, so, ia, is_, iao, ibo;
  logic         c, co, ic, ico;

  rev_vadd_top #(.N(N)) dut (
    .a_i(a), .b_i(b), .anc_i(c), .a_o(ao), .s_o(so), .anc_o(co),
    .ia_i(ia), .is_i(is_), .ianc_i(ic), .ia_o(iao), .ib_o(ibo), .ianc_o(ico)
  );

  logic [NW-1:0] wa, wb, wao, wso, wia, wis, wiao, wibo;
  logic          wc, wco, wic, wico;

  rev_vadd_top #(.N(NW)) dut_w (
    .a_i(wa), .b_i(wb), .anc_i(wc), .a_o(wao), .s_o(wso), .anc_o(wco),
    .ia_i(wia), .is_i(wis), .ianc_i(wic), .ia_o(wiao), .ib_o(wibo), .ianc_o(wico)
  );

  logic [0:0] na, nb, nao, nso, nia, nis, niao, nibo;
  logic       nc, nco, nic, nico;

  rev_vadd_top #(.N(1)) dut_1 (
    .a_i(na), .b_i(nb), .anc_i(nc), .a_o(nao), .s_o(nso), .anc_o(nco),
    .ia_i(nia), .is_i(nis), .ianc_i(nic), .ia_o(niao), .ib_o(nibo), .ianc_o(nico)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    a = '0; b = '0; c = 1'b0; ia = '0; is_ = '0; ic = 1'b0;
    wa = '0; wb = '0; wc = 1'b0; wia = '0; wis = '0; wic = 1'b0;
    na = '0; nb = '0; nc = 1'b0; nia = '0; nis = '0; nic = 1'b0;
    @(negedge clk);
    // quiescent state with all-zero lines
    check("R1 zero", 32'(so), 32'h0);
    check("R3 zero", 32'(co), 32'h0);
    check("R5 zero", 32'(ibo), 32'h0);

    // R4 R1: table walk
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {a, b, c} = VEC[i][12:4];
      @(negedge clk);
      check("R1/R4 table sum", 32'(so), 32'(VEC[i][3:0]));
      check("R2 table a", 32'(ao), 32'(VEC[i][12:9]));
      check("R3 table carry", 32'(co), 32'(VEC[i][4]));
      @(posedge clk);
      ia = ao; is_ = so; ic = co;
      @(negedge clk);
      check("R6 table b restore", 32'(ibo), 32'(VEC[i][8:5]));
    end

    // exhaustive 4-bit sweep
    for (int k = 0; k < 512; k++) begin
      @(posedge clk);
      a = k[8:5]; b = k[4:1]; c = k[0];
      ia = k[8:5]; is_ = k[4:1]; ic = k[0];
      @(negedge clk);
      check("R1 sweep sum", 32'(so), 32'((k[8:5] + k[4:1] + k[0]) & 4'hF));
      check("R2 sweep a", 32'(ao), 32'(k[8:5]));
      check("R3 sweep carry", 32'(co), 32'(k[0]));
      check("R5 reverse b", 32'(ibo), 32'((k[4:1] - k[8:5] - k[0]) & 4'hF));
      check("R5 reverse a/carry", 32'({iao, ico}), 32'({k[8:5], k[0]}));
      @(posedge clk);
      ia = ao; is_ = so; ic = co;
      @(negedge clk);
      check("R6 sweep round trip", 32'({iao, ibo, ico}), 32'({k[8:5], k[4:1], k[0]}));
    end

    // random 16-bit
    for (int k = 0; k < 2000; k++) begin
      logic [16:0] r;
      logic [NW-1:0] xa, xb;
      logic xc;
      xa = NW'($urandom); xb = NW'($urandom); xc = 1'($urandom);
      if (k == 0) begin xa = '1; xb = 16'h0001; xc = 1'b0; end
      if (k == 1) begin xa = '1; xb = '1; xc = 1'b1; end
      @(posedge clk);
      wa = xa; wb = xb; wc = xc;
      @(negedge clk);
      r = 17'(xa) + 17'(xb) + 17'(xc);
      check("R1/R4 wide sum", 32'(wso), 32'(r[15:0]));
      check("R2/R3 wide a+carry", 32'({wao, wco}), 32'({xa, xc}));
      @(posedge clk);
      wia = wao; wis = wso; wic = wco;
      @(negedge clk);
      check("R6 wide round trip", 32'(wibo), 32'(xb));
      check("R5 wide a/carry", 32'({wiao, wico}), 32'({xa, xc}));
    end

    // single-bit instance
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      na = k[2]; nb = k[1]; nc = k[0];
      nia = k[2]; nis = k[1]; nic = k[0];
      @(negedge clk);
      check("R7 one-bit sum", 32'(nso), 32'(k[2] ^ k[1] ^ k[0]));
      check("R7 one-bit a/carry", 32'({nao, nco}), 32'({k[2], k[0]}));
      check("R7 one-bit reverse", 32'(nibo), 32'(k[2] ^ k[1] ^ k[0]));
    end

    done();
  end

endmodule